// File: doc/BRIEF.md
# CAN Error-Status Flag Register

This block is the bus-status flag register of a CAN controller. The controller's protocol engine supplies the live transmit and receive error counters. From these the block derives two 2-bit bus-status codes, one for the receiver and one for the transmitter. Whenever either derived code differs from the code last reported, the block latches the new codes and raises a status-change flag.

The reported codes are blocking. While the status-change flag is pending, the codes hold their values, even if the counters move through further bands. Once the flag is cleared, the codes are refreshed from the live counters on the next clock. If anything differs, the flag is raised again. This means software always reads the codes that caused the interrupt it is servicing.

A second flag records bus activity seen during sleep when wake-up is enabled. Each flag drives its own masked interrupt output. Software clears a flag by writing 1 to its bit. While the controller is in initialization mode, both flags are held clear and writes are refused. The reported codes are not cleared in initialization mode.

Top module: `can_err_flags`

## Requirements
- R1: The receiver code is 00 for a receive count of 0..96, 01 for 97..127 and 10 for 128 and above, provided the transmit count is at most 255.
- R2: The receiver code is 11 whenever the transmit count exceeds 255, whatever the receive count.
- R3: The transmitter code is 00 for a transmit count of 0..96, 01 for 97..127, 10 for 128..255 and 11 above 255.
- R4: When the status-change flag is clear and either live code differs from the reported one, both reported codes take the live values on the next clock edge and the flag is set on that same edge.
- R5: While the status-change flag is set, the reported codes do not change, whatever the counters do.
- R6: After the status-change flag is cleared, the reported codes reload from the live counters on the next clock. The flag is set again if either code changed.
- R7: The register layout is: bit 0 wake flag, bit 1 status-change flag, bits 3:2 receiver code, bits 5:4 transmitter code, bits 7:6 always 0. Writing 1 to bit 0 or bit 1 clears that flag. Writing 0 has no effect. Bits 7:2 ignore writes.
- R8: While init_req_i and init_ack_i are both high, both flags are forced clear, writes are ignored and the wake flag cannot be set. Either signal alone has no such effect.
- R9: Initialization mode does not clear the reported codes.
- R10: The wake flag is set on the clock edge after sleep_i, wake_en_i and bus_act_i are all high outside initialization mode. A set and a clear on the same edge leave the flag set.
- R11: wake_irq_o is high exactly when the wake flag and wake_irq_en_i are both high. stat_irq_o is high exactly when the status-change flag and stat_irq_en_i are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tec_i | input | 9 | Live transmit error count |
| rec_i | input | 8 | Live receive error count |
| sleep_i | input | 1 | Controller is in sleep mode |
| bus_act_i | input | 1 | Bus activity detected |
| wake_en_i | input | 1 | Wake-up detection enable |
| init_req_i | input | 1 | Initialization mode request |
| init_ack_i | input | 1 | Initialization mode acknowledge |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data, 1 clears the flag in that bit |
| rd_data_o | output | 8 | Register read value |
| wake_irq_en_i | input | 1 | Wake interrupt mask enable |
| stat_irq_en_i | input | 1 | Status-change interrupt mask enable |
| wake_irq_o | output | 1 | Masked wake interrupt |
| stat_irq_o | output | 1 | Masked status-change interrupt |

## Verification
The counters are stepped to both sides of every band edge: 96/97, 127/128, 255/256 on transmit, and 96/97, 127/128 on receive. A mistaken comparison shows up as a missed or spurious flag. One test moves the receive count twice while the flag is pending, then clears it. This separates a frozen register from one that tracks the counters, and it also shows that the reload after a clear re-raises the flag. Other tests enter initialization mode with both flags set and nonzero codes. Together with a one-signal-only case, they distinguish a correct flag reset from one that also wipes the codes or that triggers on a single signal.

// File: rtl/can_ef_pkg.sv
package can_ef_pkg;
  typedef enum logic [1:0] {
    ST_OK      = 2'b00,
    ST_WARN    = 2'b01,
    ST_PASSIVE = 2'b10,
    ST_BUSOFF  = 2'b11
  } bus_st_e;

  localparam int unsigned BIT_WAKE = 0;
  localparam int unsigned BIT_CHG  = 1;
  localparam int unsigned RX_LO    = 2;
  localparam int unsigned TX_LO    = 4;
endpackage

// File: rtl/can_ef_classify.sv
module can_ef_classify
  import can_ef_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned WARN_LIM = 96,
  parameter int unsigned PASS_LIM = 127
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             busoff_i,
  output bus_st_e          code_o
);
  localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);

  always_comb begin
    if (busoff_i)           code_o = ST_BUSOFF;
    else if (cnt_i > PASS_C) code_o = ST_PASSIVE;
    else if (cnt_i > WARN_C) code_o = ST_WARN;
    else                     code_o = ST_OK;
  end
endmodule

// File: rtl/can_ef_status.sv
module can_ef_status
  import can_ef_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    hold_i,
  input  logic    clr_i,
  input  bus_st_e live_rx_i,
  input  bus_st_e live_tx_i,
  output bus_st_e rx_o,
  output bus_st_e tx_o,
  output logic    chg_o
);
  logic differ;
  assign differ = (live_rx_i != rx_o) || (live_tx_i != tx_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_o  <= ST_OK;
      tx_o  <= ST_OK;
      chg_o <= 1'b0;
    end else if (hold_i) begin
      // codes keep tracking in init mode, flag held clear
      rx_o  <= live_rx_i;
      tx_o  <= live_tx_i;
      chg_o <= 1'b0;
    end else if (!chg_o && differ) begin
      rx_o  <= live_rx_i;
      tx_o  <= live_tx_i;
      chg_o <= 1'b1;
    end else if (clr_i) begin
      chg_o <= 1'b0;
    end
  end
endmodule

// File: rtl/can_ef_wake.sv
module can_ef_wake (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (hold_i) flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/can_err_flags.sv
module can_err_flags
  import can_ef_pkg::*;
#(
  parameter int unsigned TEC_W     = 9,
  parameter int unsigned REC_W     = 8,
  parameter int unsigned WARN_LIM  = 96,
  parameter int unsigned PASS_LIM  = 127,
  parameter int unsigned BOFF_LIM  = 255
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  input  logic             sleep_i,
  input  logic             bus_act_i,
  input  logic             wake_en_i,
  input  logic             init_req_i,
  input  logic             init_ack_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  input  logic             wake_irq_en_i,
  input  logic             stat_irq_en_i,
  output logic             wake_irq_o,
  output logic             stat_irq_o
);
  localparam logic [TEC_W-1:0] BOFF_C = TEC_W'(BOFF_LIM);

  logic    in_init, wr_ok, busoff;
  bus_st_e live_rx, live_tx, rx_q, tx_q;
  logic    chg_q, wake_q;

  assign in_init = init_req_i & init_ack_i;
  assign wr_ok   = wr_en_i & ~in_init;
  assign busoff  = tec_i > BOFF_C;

  can_ef_classify #(.CNT_W(REC_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_rx_cls (
    .cnt_i(rec_i), .busoff_i(busoff), .code_o(live_rx));

  can_ef_classify #(.CNT_W(TEC_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_tx_cls (
    .cnt_i(tec_i), .busoff_i(busoff), .code_o(live_tx));

  can_ef_status u_status (
    .clk_i, .rst_ni, .hold_i(in_init),
    .clr_i(wr_ok & wr_data_i[BIT_CHG]),
    .live_rx_i(live_rx), .live_tx_i(live_tx),
    .rx_o(rx_q), .tx_o(tx_q), .chg_o(chg_q));

  can_ef_wake u_wake (
    .clk_i, .rst_ni, .hold_i(in_init),
    .set_i(sleep_i & wake_en_i & bus_act_i),
    .clr_i(wr_ok & wr_data_i[BIT_WAKE]),
    .flag_o(wake_q));

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[BIT_WAKE]         = wake_q;
    rd_data_o[BIT_CHG]          = chg_q;
    rd_data_o[RX_LO+1:RX_LO]    = rx_q;
    rd_data_o[TX_LO+1:TX_LO]    = tx_q;
  end

  assign wake_irq_o = wake_q & wake_irq_en_i;
  assign stat_irq_o = chg_q & stat_irq_en_i;
endmodule

// File: rtl/can_err_flags_chk.sv
module can_err_flags_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sleep_i,
  input logic       bus_act_i,
  input logic       wake_en_i,
  input logic       init_req_i,
  input logic       init_ack_i,
  input logic [7:0] rd_data_o,
  input logic       wake_irq_o,
  input logic       stat_irq_o
);
  logic init_on;
  assign init_on = init_req_i & init_ack_i;

  // R4
  chg_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_data_o[1]) |-> (rd_data_o[5:2] != $past(rd_data_o[5:2])));

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[1] && !init_on) |=> $stable(rd_data_o[5:2]));

  // R8
  init_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_on |=> (rd_data_o[1:0] == 2'b00));

  // R10
  wake_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && wake_en_i && bus_act_i && !init_on) |=> rd_data_o[0]);

  // R7
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7:6] == 2'b00);

  // R11
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_data_o[0] |-> !wake_irq_o) and (!rd_data_o[1] |-> !stat_irq_o));
endmodule

bind can_err_flags can_err_flags_chk u_chk (
  .clk_i, .rst_ni, .sleep_i, .bus_act_i, .wake_en_i,
  .init_req_i, .init_ack_i, .rd_data_o, .wake_irq_o, .stat_irq_o);

// File: tb/can_err_flags_test.sv
module can_err_flags_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] tec = '0;
  logic [7:0] rec = '0;
  logic       sleep = 0, act = 0, wen = 0, ireq = 0, iack = 0, wr = 0;
  logic [7:0] wdata = '0;
  logic [7:0] rd;
  logic       wie = 0, sie = 0, wirq, sirq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  can_err_flags uut (
    .clk_i(clk), .rst_ni(rst_n), .tec_i(tec), .rec_i(rec),
    .sleep_i(sleep), .bus_act_i(act), .wake_en_i(wen),
    .init_req_i(ireq), .init_ack_i(iack), .wr_en_i(wr), .wr_data_i(wdata),
    .rd_data_o(rd), .wake_irq_en_i(wie), .stat_irq_en_i(sie),
    .wake_irq_o(wirq), .stat_irq_o(sirq));

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [7:0] exp, input string tag);
    checks++;
    if (rd !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%02h expected %02h", tag, rd, exp);
    end
  endtask

  task automatic chk_bit(input logic act_v, input logic exp, input string tag);
    checks++;
    if (act_v !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", tag, act_v, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    wr = 1'b1; wdata = d;
    step();
    wr = 1'b0; wdata = '0;
  endtask

  task automatic t_reset();
    chk(8'h00, "R7 reset value");
    chk_bit(wirq, 1'b0, "R11 reset wake irq");
    chk_bit(sirq, 1'b0, "R11 reset stat irq");
  endtask

  task automatic t_rx_bands();
    rec = 8'd96; step(); step();
    chk(8'h00, "R1 rec 96 stays ok");
    rec = 8'd97; step();
    chk(8'h06, "R1 R4 rec 97 warn");
    wr_reg(8'h02);
    chk(8'h04, "R7 clear status flag");
    rec = 8'd127; step();
    chk(8'h04, "R1 rec 127 still warn");
    rec = 8'd128; step();
    chk(8'h0A, "R1 rec 128 passive");
    wr_reg(8'h02);
    rec = 8'd0; step();
    chk(8'h02, "R1 back to ok");
    wr_reg(8'h02); step();
    chk(8'h00, "R6 no reassert when equal");
  endtask

  task automatic t_tx_bands();
    tec = 9'd96; step(); step();
    chk(8'h00, "R3 tec 96 ok");
    tec = 9'd97; step();
    chk(8'h12, "R3 tec 97 warn");
    wr_reg(8'h02);
    tec = 9'd128; step();
    chk(8'h22, "R3 tec 128 passive");
    wr_reg(8'h02);
    tec = 9'd255; step();
    chk(8'h20, "R3 tec 255 still passive");
    tec = 9'd256; step();
    chk(8'h3E, "R2 R3 tec 256 busoff both");
    wr_reg(8'h02);
    tec = 9'd0; step();
    chk(8'h02, "R3 tec back to ok");
    wr_reg(8'h02); step();
    chk(8'h00, "R3 idle");
  endtask

  task automatic t_freeze();
    rec = 8'd128; step();
    chk(8'h0A, "R4 passive reported");
    rec = 8'd50; step();
    chk(8'h0A, "R5 frozen with rec 50");
    rec = 8'd110; step();
    chk(8'h0A, "R5 frozen with rec 110");
    wr_reg(8'h02);
    chk(8'h08, "R6 cleared, code kept");
    step();
    chk(8'h06, "R6 reload warn and reassert");
    wr_reg(8'h02);
    rec = 8'd0; step();
    wr_reg(8'h02); step();
    chk(8'h00, "R6 settle");
  endtask

  task automatic t_write();
    rec = 8'd97; step();
    wr_reg(8'h00);
    chk(8'h06, "R7 write zero no effect");
    wr_reg(8'hFD);
    chk(8'h06, "R7 code bits read-only");
    sie = 1'b1; #1;
    chk_bit(sirq, 1'b1, "R11 stat irq enabled");
    sie = 1'b0; #1;
    chk_bit(sirq, 1'b0, "R11 stat irq masked");
    wr_reg(8'h02);
    rec = 8'd0; step();
    wr_reg(8'h02); step();
    chk(8'h00, "R7 settle");
  endtask

  task automatic t_wake();
    sleep = 1; act = 1; wen = 0; step();
    chk(8'h00, "R10 no wake when disabled");
    wen = 1; step();
    chk(8'h01, "R10 wake set");
    wr_reg(8'h01);
    chk(8'h01, "R10 set wins over clear");
    act = 0; #1;
    chk_bit(wirq, 1'b0, "R11 wake irq masked");
    wie = 1; #1;
    chk_bit(wirq, 1'b1, "R11 wake irq enabled");
    wr_reg(8'h01);
    chk(8'h00, "R7 wake cleared");
    sleep = 0; act = 1; step();
    chk(8'h00, "R10 no wake when awake");
    act = 0; wen = 0; wie = 0;
  endtask

  task automatic t_init();
    sleep = 1; act = 1; wen = 1; step();
    act = 0; rec = 8'd97; step();
    chk(8'h07, "R8 both flags before init");
    ireq = 1; step();
    chk(8'h07, "R8 request alone no effect");
    iack = 1; step();
    chk(8'h04, "R8 R9 flags reset code kept");
    act = 1; wr_reg(8'h02); step();
    chk(8'h04, "R8 wake blocked in init");
    act = 0; sleep = 0; wen = 0; ireq = 0; iack = 0; step();
    chk(8'h04, "R9 code survives exit");
    rec = 8'd128; step();
    chk(8'h0A, "R8 flag works after exit");
    wr_reg(8'h02);
    chk(8'h08, "R8 writable after exit");
    rec = 8'd0; step();
    wr_reg(8'h02); step();
    chk(8'h00, "R8 settle");
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_bands();
    t_tx_bands();
    t_freeze();
    t_write();
    t_wake();
    t_init();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule